// File: doc/BRIEF.md
# Wavelet Synthesis Filter Bank Stage

This block performs one level of inverse discrete wavelet transform on fixed-point data. It takes a half-rate approximation band and a half-rate detail band and widens each to full rate by placing a zero after every received sample. Each widened band then runs through its own four-tap shift register and four-tap FIR filter, using the time-reversed fourth-order orthogonal (two-vanishing-moment) wavelet coefficients quantised to 16 bits with 15 fraction bits. The two filter results are added, scaled back by 2^15 and registered. One full-rate sample leaves the block on every clock.

A matching analysis stage uses the forward low-pass and high-pass filters and keeps the even-phase outputs. When that stage drives this one, the output reproduces the analysis input delayed by a fixed number of samples, apart from a few LSB of quantisation. Stages can be chained for multi-level reconstruction, with each level running at twice the sample rate of the level before it.

A small controller has three states. ST_IDLE waits for the first band strobe. ST_FILL covers the clocks while the pipeline primes. ST_RUN keeps the output-valid flag high until reset. The move from ST_IDLE to ST_FILL is the *start* transition, taken on the first `band_vld`. The move from ST_FILL to ST_RUN is the *primed* transition, taken when the fill count is done.

Top module: `wsyn_synth_stage`

## Requirements
- R1: A clock with `band_vld` high captures `approx_in` and `detail_in` as the samples for that full-rate slot. A clock with `band_vld` low places a zero into both filter histories, so strobes on alternate clocks upsample each band by two.
- R2: Values on `approx_in` and `detail_in` during clocks with `band_vld` low have no effect on `recon_out`.
- R3: `recon_out[n]` = floor((Σj LS[j]·a[n−j] + Σj HS[j]·d[n−j]) / 2^15), truncated to DATA_W bits, where a and d are the zero-stuffed bands. j = 0 is the newest sample, and history from before the last reset is zero. The coefficients are LS = {−4240, 7345, 27411, 15826} and HS = {−15826, 27411, −7345, −4240}, with index j = 0..3.
- R4: Full-rate slot n is captured on a rising edge. Its result is registered two rising edges later, and one result is produced per clock.
- R5: The bands can come from the matching analysis filters: a[m] = floor(Σk H[k]·x[2m−k] / 2^15) with H = {15826, 27411, 7345, −4240}, and d[m] likewise with G = {−4240, −7345, 27411, −15826}. Fed this way, `recon_out` at full-rate index n equals x[n−3] to within ±3 LSB. The delay of 3 samples is the package constant RECON_DELAY.
- R6: `recon_vld` is low after reset. It rises with the result of the first strobed slot, which is registered two edges after that strobe's capture edge. It then stays high until reset.
- R7: Reset clears both tap lines, the product registers and the output. During reset `recon_out` is 0 and `recon_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| band_vld | input | 1 | Band samples present on this clock |
| approx_in | input | DATA_W | Approximation band sample, signed |
| detail_in | input | DATA_W | Detail band sample, signed |
| recon_vld | output | 1 | Reconstructed stream is valid |
| recon_out | output | DATA_W | Reconstructed full-rate sample, signed |

## Verification
The block is driven with four patterns, and each one isolates a different part of the behaviour:
- **Ramp 1, 2, 3, …** The bench passes the ramp through its own analysis model and feeds the resulting bands to the block. This shows whether the coefficient ordering and the zero-insertion phase cancel aliasing and give back the delayed ramp. A wrong tap order or phase leaves a visible periodic error.
- **Lone impulses in each band** An impulse in only one band brings out that band's four coefficients one at a time. This separates the low-pass filter from the high-pass filter and exposes a swapped sign.
- **Seeded random bands near half scale** These stress the sign extension and the floor shift on negative sums.
- **Silent stream with extreme values off-strobe** Silent bands with extreme values driven on off-strobe clocks must produce zero output, which shows the off-strobe inputs are ignored.

Every stream except the first starts with a reset issued mid-run, which checks that no history survives reset.

// File: rtl/wsyn_pkg.sv
package wsyn_pkg;

    // Filter geometry shared by every level of the reconstruction tree.
    localparam int TAPS        = 4;
    localparam int NBANDS      = 2;
    localparam int COEF_W      = 16;
    localparam int FRAC_BITS   = 15;
    // Register stages from capture to output: tap line, products, output sum.
    localparam int PIPE_LAT    = 3;
    // Samples between analysis input and reconstructed output.
    localparam int RECON_DELAY = TAPS - 1;

    localparam int BAND_LOW    = 0;
    localparam int BAND_HIGH   = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } wsyn_state_e;

    // Synthesis coefficients: time-reversed analysis set, scaled by 2^15.
    // Tap 0 multiplies the newest sample of the upsampled band.
    function automatic logic signed [COEF_W-1:0] synth_coef(input int band, input int tap);
        logic signed [COEF_W-1:0] c;
        case (band * TAPS + tap)
            0:       c = -16'sd4240;
            1:       c =  16'sd7345;
            2:       c =  16'sd27411;
            3:       c =  16'sd15826;
            4:       c = -16'sd15826;
            5:       c =  16'sd27411;
            6:       c = -16'sd7345;
            7:       c = -16'sd4240;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wsyn_tapline.sv
module wsyn_tapline
    import wsyn_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NTAPS  = TAPS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          band_vld,
    input  logic [DATA_W-1:0]             sample_in,
    output logic [NTAPS-1:0][DATA_W-1:0]  taps
);

    // Zero-stuffing upsampler feeding a shift register: a strobed clock
    // pushes the band sample, any other clock pushes zero.
    logic [DATA_W-1:0] stuffed;

    always_comb begin
        stuffed = band_vld ? sample_in : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps <= '0;
        end else begin
            taps[0] <= stuffed;
            for (int i = 1; i < NTAPS; i++) begin
                taps[i] <= taps[i-1];
            end
        end
    end

endmodule

// File: rtl/wsyn_fir4.sv
module wsyn_fir4
    import wsyn_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NTAPS  = TAPS,
    parameter int BAND   = BAND_LOW,
    localparam int PROD_W = DATA_W + COEF_W,
    localparam int SUM_W  = PROD_W + $clog2(NTAPS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NTAPS-1:0][DATA_W-1:0]  taps,
    output logic signed [SUM_W-1:0]       psum
);

    logic signed [PROD_W-1:0] prod_q [NTAPS];

    // One registered multiplier per tap; operands sign-extended to full width.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAPS; i++) begin
                prod_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NTAPS; i++) begin
                prod_q[i] <= PROD_W'($signed(taps[i])) * PROD_W'(synth_coef(BAND, i));
            end
        end
    end

    // Adder tree over the registered products, resolved in the next stage.
    always_comb begin
        psum = '0;
        for (int i = 0; i < NTAPS; i++) begin
            psum = psum + SUM_W'(prod_q[i]);
        end
    end

endmodule

// File: rtl/wsyn_ctrl.sv
module wsyn_ctrl
    import wsyn_pkg::*;
#(
    parameter int FILL_CYCLES = PIPE_LAT,
    localparam int CNT_W = $clog2(FILL_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic band_vld,
    output logic recon_vld
);

    wsyn_state_e state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    // Next state: start on the first strobe, primed once the fill count
    // reaches the point where the first result lands in the output register.
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (band_vld) begin
                    state_n = ST_FILL;
                    cnt_n   = '0;
                end
            end
            ST_FILL: begin
                if (cnt_q == CNT_W'(FILL_CYCLES - 2)) begin
                    state_n = ST_RUN;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                state_n = ST_RUN;
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Moore output.
    always_comb begin
        recon_vld = (state_q == ST_RUN);
    end

    // R6: once valid, stays valid until reset.
    a_r6_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        recon_vld |=> recon_vld);

    // R6: valid rises exactly when the first strobed slot reaches the output.
    a_r6_rise_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recon_vld) |-> $past(band_vld, 3));

endmodule

// File: rtl/wsyn_synth_stage.sv
module wsyn_synth_stage
    import wsyn_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int PROD_W = DATA_W + COEF_W,
    localparam int SUM_W  = PROD_W + $clog2(TAPS),
    localparam int ACC_W  = SUM_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              band_vld,
    input  logic [DATA_W-1:0] approx_in,
    input  logic [DATA_W-1:0] detail_in,
    output logic              recon_vld,
    output logic [DATA_W-1:0] recon_out
);

    logic signed [SUM_W-1:0] band_psum [NBANDS];
    logic signed [ACC_W-1:0] total;

    // One upsampler, tap line and filter per band.
    for (genvar b = 0; b < NBANDS; b++) begin : gen_band
        logic [DATA_W-1:0]            band_sample;
        logic [TAPS-1:0][DATA_W-1:0]  band_taps;

        if (b == BAND_LOW) begin : gen_sel_low
            assign band_sample = approx_in;
        end else begin : gen_sel_high
            assign band_sample = detail_in;
        end

        wsyn_tapline #(
            .DATA_W (DATA_W),
            .NTAPS  (TAPS)
        ) u_tapline (
            .clk       (clk),
            .rst_n     (rst_n),
            .band_vld  (band_vld),
            .sample_in (band_sample),
            .taps      (band_taps)
        );

        wsyn_fir4 #(
            .DATA_W (DATA_W),
            .NTAPS  (TAPS),
            .BAND   (b)
        ) u_fir (
            .clk   (clk),
            .rst_n (rst_n),
            .taps  (band_taps),
            .psum  (band_psum[b])
        );
    end

    // Band merge and descale: arithmetic shift gives floor division.
    always_comb begin
        total = ACC_W'(band_psum[BAND_LOW]) + ACC_W'(band_psum[BAND_HIGH]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            recon_out <= '0;
        end else begin
            recon_out <= DATA_W'(total >>> FRAC_BITS);
        end
    end

    wsyn_ctrl #(
        .FILL_CYCLES (PIPE_LAT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .band_vld  (band_vld),
        .recon_vld (recon_vld)
    );

    // R1: band strobes arrive on alternate clocks at most.
    a_r1_strobe_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        band_vld |=> !band_vld);

    // R1/R2: four unstrobed slots flush only zeros through to the output,
    // whatever is on the band inputs meanwhile.
    a_r1_zero_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(band_vld, 3) && !$past(band_vld, 4) &&
         !$past(band_vld, 5) && !$past(band_vld, 6)) |-> (recon_out == '0));

endmodule

// File: tb/wsyn_synth_stage_test.sv
module wsyn_synth_stage_test;
    import wsyn_pkg::*;

    localparam int DW   = 16;
    localparam int MAXN = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          band_vld = 1'b0;
    logic [DW-1:0] approx_in = '0;
    logic [DW-1:0] detail_in = '0;
    logic          recon_vld;
    logic [DW-1:0] recon_out;

    int n_cmp = 0;
    int n_bad = 0;

    int ua [MAXN];
    int ud [MAXN];
    int xin [MAXN];

    int ls [4] = '{-4240, 7345, 27411, 15826};
    int hs [4] = '{-15826, 27411, -7345, -4240};
    int ha [4] = '{15826, 27411, 7345, -4240};
    int ga [4] = '{-4240, -7345, 27411, -15826};

    always #4 clk = ~clk;

    wsyn_synth_stage #(.DATA_W(DW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .band_vld  (band_vld),
        .approx_in (approx_in),
        .detail_in (detail_in),
        .recon_vld (recon_vld),
        .recon_out (recon_out)
    );

    function automatic int wrap16(longint v);
        logic signed [DW-1:0] w;
        w = DW'(v);
        return int'(w);
    endfunction

    // Expected output per R3 from the zero-stuffed band arrays.
    function automatic int model_y(int n);
        longint acc = 0;
        for (int j = 0; j < 4; j++) begin
            if (n - j >= 0) begin
                acc += longint'(ls[j]) * ua[n-j] + longint'(hs[j]) * ud[n-j];
            end
        end
        return wrap16(acc >>> 15);
    endfunction

    function automatic int xat(int i);
        return (i < 0) ? 0 : xin[i];
    endfunction

    task automatic clear_streams();
        for (int i = 0; i < MAXN; i++) begin
            ua[i] = 0; ud[i] = 0; xin[i] = 0;
        end
    endtask

    task automatic check(string req, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_near(string req, int got, int exp, int tol);
        n_cmp++;
        if (got > exp + tol || got < exp - tol) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (+/-%0d)", req, got, exp, tol);
        end
    endtask

    // R7: reset mid-run clears everything.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        band_vld = 1'b0;
        approx_in = DW'($urandom);
        detail_in = DW'($urandom);
        repeat (3) @(negedge clk);
        check("R7 reset valid", int'(recon_vld), 0);
        check("R7 reset data", wrap16(longint'($signed(recon_out))), 0);
        rst_n = 1'b1;
    endtask

    // Drive len full-rate slots (strobe on even slots) and check every output.
    task automatic run_stream(int len, string tag, bit recon, bit extreme_junk);
        for (int t = 0; t < len + 2; t++) begin
            band_vld = (t % 2 == 0);
            if (band_vld) begin
                approx_in = DW'(ua[t]);
                detail_in = DW'(ud[t]);
            end else if (extreme_junk) begin
                approx_in = (t % 4 == 1) ? 16'h7FFF : 16'h8000;
                detail_in = (t % 4 == 1) ? 16'h8000 : 16'h7FFF;
            end else begin
                approx_in = DW'($urandom);
                detail_in = DW'($urandom);
            end
            @(negedge clk);
            if (t < 2) begin
                check("R6 not yet valid", int'(recon_vld), 0);
            end else begin
                int n = t - 2;
                int got = wrap16(longint'($signed(recon_out)));
                check("R6 valid held", int'(recon_vld), 1);
                check($sformatf("%s R4 slot %0d", tag, n), got, model_y(n));
                if (recon && n < len) begin
                    check_near($sformatf("R5 slot %0d", n), got, xat(n - RECON_DELAY), 3);
                end
            end
        end
        band_vld = 1'b0;
    endtask

    // Analysis model used to derive bands from a full-rate input (R5).
    task automatic analyse(int len);
        for (int m = 0; 2 * m < len; m++) begin
            longint sa = 0;
            longint sd = 0;
            for (int k = 0; k < 4; k++) begin
                sa += longint'(ha[k]) * xat(2 * m - k);
                sd += longint'(ga[k]) * xat(2 * m - k);
            end
            ua[2*m] = int'(sa >>> 15);
            ud[2*m] = int'(sd >>> 15);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        clear_streams();
        do_reset();

        // Ramp through the analysis model: R5 reconstruction and exact R3.
        clear_streams();
        for (int i = 0; i < 80; i++) xin[i] = i + 1;
        analyse(80);
        run_stream(80, "R3 ramp", 1'b1, 1'b0);

        // Seeded random bands, reset first so no ramp history remains (R7).
        do_reset();
        clear_streams();
        for (int m = 0; m < 100; m++) begin
            ua[2*m] = int'($urandom_range(32768)) - 16384;
            ud[2*m] = int'($urandom_range(32768)) - 16384;
        end
        ua[0] = -16384; ud[0] = -16384;
        ua[2] = 16384;  ud[2] = 16384;
        run_stream(200, "R3 random", 1'b0, 1'b0);

        // Impulses: approx at slot 0, detail at slot 8 (R1 zero insertion).
        do_reset();
        clear_streams();
        ua[0] = 16384;
        ud[8] = -16384;
        run_stream(20, "R1 impulse", 1'b0, 1'b0);

        // Silent bands with extreme off-strobe values: output stays zero (R2).
        do_reset();
        clear_streams();
        run_stream(24, "R2 silent", 1'b0, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule